// File: doc/BRIEF.md
# A20-Aware Cacheability Decision Unit

This unit sits in front of an on-chip cache and rules on every memory access: may the access be cached, and which address should the cache look up? It can model the address-bit-20 wrap-around that a PC-compatible system applies outside the processor, so the cache never holds data under an alias that the memory system would resolve differently.

Because the state of that wrap-around may be unknown, the unit refuses by default to cache the lowest 64KB of every 1MB block. Software can lift this once the wrap state is known to be stable. A programmable non-cacheable window and an optional external active-low cache-enable input can also veto caching. Out of reset, caching is off and both optional inputs are ignored. Configuration is loaded as a whole with a single load strobe.

Each access is presented with a valid strobe. The decision and the lookup address appear one clock later and stay unchanged until the next strobe.

Top module: `a20CacheGate`

## Requirements
- R1: Reset clears `cacheable` and `lookupAddr` to 0 and every configuration field to 0. Until a configuration with `cfgCacheOn`=1 is loaded, every access yields `cacheable`=0.
- R2: The unit evaluates an access in the clock edge where `addrValid`=1. The outputs change at that edge and hold their values through every later cycle with `addrValid`=0.
- R3: When `cfgA20PinOn`=1 and `a20MaskN`=0, `lookupAddr` equals `addrIn` with bit 20 forced to 0. In every other case `lookupAddr` equals `addrIn`, so `a20MaskN` has no effect while `cfgA20PinOn`=0.
- R4: While `cfgLowMegOk`=0, an access with address bits 19:16 all zero yields `cacheable`=0. This is an offset below 64KB within its 1MB block.
- R5: With `cfgLowMegOk`=1, an offset below 64KB within its 1MB block does not on its own prevent caching.
- R6: When `cfgExtPinOn`=1 and `extCacheEnN`=1, the access yields `cacheable`=0. While `cfgExtPinOn`=0, `extCacheEnN` has no effect.
- R7: When `cfgNcOn`=1, an access yields `cacheable`=0 if the masked lookup address and `cfgNcBase` agree in all bits at or above position `cfgNcSizeLog2`. A size exponent of 32 or more covers the whole address space.
- R8: With `cfgCacheOn`=0, `cacheable` is 0 for every access.
- R9: `cfgLoad`=1 stores all configuration inputs at that clock edge. An access strobed in the same edge is judged with the configuration held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Store all cfg* inputs |
| cfgCacheOn | input | 1 | Global cache enable |
| cfgA20PinOn | input | 1 | Honour `a20MaskN` |
| cfgExtPinOn | input | 1 | Honour `extCacheEnN` |
| cfgLowMegOk | input | 1 | Lift the low-64KB-per-MB exclusion |
| cfgNcOn | input | 1 | Enable the non-cacheable window |
| cfgNcBase | input | 32 | Non-cacheable window base |
| cfgNcSizeLog2 | input | 6 | Window size as a power-of-two exponent |
| addrValid | input | 1 | Access strobe |
| addrIn | input | 32 | Physical address of the access |
| a20MaskN | input | 1 | Active-low address-bit-20 mask request |
| extCacheEnN | input | 1 | Active-low external cache enable |
| cacheable | output | 1 | Access may be cached |
| lookupAddr | output | 32 | Address for the cache lookup |

## Verification
The hardest case to reach from the ports is a configuration load and an access strobed in the same clock edge. Here the access must still be judged with the old settings. The stimulus raises `cfgLoad` and `addrValid` together, with a new configuration that would flip the verdict. A second hard case is a non-cacheable window hit that only occurs after bit 20 is masked. The stimulus puts the window at 0 and drives an address of exactly 1MB plus an offset, with the mask request active.

// File: rtl/a20CacheGatePkg.sv
package a20CacheGatePkg;
  localparam int ADDR_W   = 32;
  localparam int A20_BIT  = 20;
  localparam int MEG_BITS = 20;
  localparam int LOW_BITS = 16;
  localparam int SIZE_W   = $clog2(ADDR_W + 1);

  typedef struct packed {
    logic capture;
    logic cfgTake;
  } gateStrobes_t;

  typedef struct packed {
    logic              cacheOn;
    logic              a20PinOn;
    logic              extPinOn;
    logic              lowMegOk;
    logic              ncOn;
    logic [ADDR_W-1:0] ncBase;
    logic [SIZE_W-1:0] ncSizeLog2;
  } gateCfg_t;
endpackage

// File: rtl/a20CacheGateCtrl.sv
module a20CacheGateCtrl
  import a20CacheGatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrValid,
  input  logic         cfgLoad,
  output gateStrobes_t strobes
);
  always_comb begin
    strobes.capture = addrValid;
    strobes.cfgTake = cfgLoad;
  end

  // The datapath relies on strobes being clean after reset.
  assert_strobe_known_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(strobes));
endmodule

// File: rtl/a20CacheGateDp.sv
module a20CacheGateDp
  import a20CacheGatePkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SIZE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  gateStrobes_t  strobes,
  input  gateCfg_t      cfgIn,
  input  logic [AW-1:0] addrIn,
  input  logic          a20MaskN,
  input  logic          extCacheEnN,
  output logic          cacheableQ,
  output logic [AW-1:0] lookupQ
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  gateCfg_t      cfgQ;
  logic [AW-1:0] maskedAddr;
  logic [AW-1:0] ncMask;
  logic          lowHit, ncHit, extOk, decide;

  always_ff @(posedge clk) begin
    if (!rstN)                cfgQ <= '0;
    else if (strobes.cfgTake) cfgQ <= cfgIn;
  end

  always_comb begin
    maskedAddr = addrIn;
    if (cfgQ.a20PinOn && !a20MaskN) maskedAddr[A20_BIT] = 1'b0;
    lowHit = (maskedAddr[MEG_BITS-1:LOW_BITS] == '0);
    ncMask = ALL_ONES << cfgQ.ncSizeLog2;
    ncHit  = cfgQ.ncOn && ((maskedAddr & ncMask) == (cfgQ.ncBase & ncMask));
    extOk  = !cfgQ.extPinOn || !extCacheEnN;
    decide = cfgQ.cacheOn && (cfgQ.lowMegOk || !lowHit) && !ncHit && extOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheableQ <= 1'b0;
      lookupQ    <= '0;
    end else if (strobes.capture) begin
      cacheableQ <= decide;
      lookupQ    <= maskedAddr;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(cacheableQ) && $stable(lookupQ)));
  assert_a20_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && cfgQ.a20PinOn && !a20MaskN) |=> !lookupQ[A20_BIT]);
  assert_low_bits_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (lookupQ[A20_BIT-1:0] == $past(addrIn[A20_BIT-1:0])));
  assert_low_meg_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !cfgQ.lowMegOk && addrIn[MEG_BITS-1:LOW_BITS] == '0)
      |=> !cacheableQ);
  assert_ext_veto_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && cfgQ.extPinOn && extCacheEnN) |=> !cacheableQ);
  assert_global_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !cfgQ.cacheOn) |=> !cacheableQ);
endmodule

// File: rtl/a20CacheGate.sv
module a20CacheGate
  import a20CacheGatePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgCacheOn,
  input  logic              cfgA20PinOn,
  input  logic              cfgExtPinOn,
  input  logic              cfgLowMegOk,
  input  logic              cfgNcOn,
  input  logic [ADDR_W-1:0] cfgNcBase,
  input  logic [SIZE_W-1:0] cfgNcSizeLog2,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              a20MaskN,
  input  logic              extCacheEnN,
  output logic              cacheable,
  output logic [ADDR_W-1:0] lookupAddr
);
  gateStrobes_t strobes;
  gateCfg_t     cfgBundle;

  always_comb begin
    cfgBundle.cacheOn    = cfgCacheOn;
    cfgBundle.a20PinOn   = cfgA20PinOn;
    cfgBundle.extPinOn   = cfgExtPinOn;
    cfgBundle.lowMegOk   = cfgLowMegOk;
    cfgBundle.ncOn       = cfgNcOn;
    cfgBundle.ncBase     = cfgNcBase;
    cfgBundle.ncSizeLog2 = cfgNcSizeLog2;
  end

  a20CacheGateCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .cfgLoad(cfgLoad),
    .strobes(strobes)
  );

  a20CacheGateDp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgIn(cfgBundle),
    .addrIn(addrIn), .a20MaskN(a20MaskN), .extCacheEnN(extCacheEnN),
    .cacheableQ(cacheable), .lookupQ(lookupAddr)
  );
endmodule

// File: tb/a20CacheGate_tb_top.sv
`timescale 1ns/1ps
module a20CacheGate_tb_top;
  logic clk = 0, rstN = 0;
  logic cfgLoad = 0, cfgCacheOn = 0, cfgA20PinOn = 0, cfgExtPinOn = 0;
  logic cfgLowMegOk = 0, cfgNcOn = 0;
  logic [31:0] cfgNcBase = 0;
  logic [5:0]  cfgNcSizeLog2 = 0;
  logic addrValid = 0;
  logic [31:0] addrIn = 0;
  logic a20MaskN = 1, extCacheEnN = 0;
  logic cacheable;
  logic [31:0] lookupAddr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic        expC[$];
  logic [31:0] expA[$];
  string       expT[$];
  // bench model of the stored configuration
  bit mOn = 0, mA20 = 0, mExt = 0, mLow = 0, mNc = 0;
  logic [31:0] mBase = 0;
  int mLog2 = 0;
  logic        lastC = 0;
  logic [31:0] lastA = 0;

  always #2 clk = ~clk;

  a20CacheGate dut_i (.*);

  function automatic logic [31:0] modelAddr(logic [31:0] a, logic mN);
    return (mA20 && !mN) ? (a & ~(32'd1 << 20)) : a;
  endfunction

  function automatic logic modelCache(logic [31:0] a, logic mN, logic eN);
    logic [31:0] m = modelAddr(a, mN);
    bit inLow = (m % 32'h10_0000) < 32'h1_0000;
    bit inNc  = mNc && ((mLog2 >= 32) || ((m >> mLog2) == (mBase >> mLog2)));
    bit extVeto = mExt && eN;
    return mOn && (mLow || !inLow) && !inNc && !extVeto;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic loadCfg(bit on, bit a20, bit ext, bit low, bit nc,
                         logic [31:0] base, int lg);
    @(negedge clk);
    cfgLoad = 1; cfgCacheOn = on; cfgA20PinOn = a20; cfgExtPinOn = ext;
    cfgLowMegOk = low; cfgNcOn = nc; cfgNcBase = base; cfgNcSizeLog2 = 6'(lg);
    @(negedge clk);
    cfgLoad = 0;
    mOn = on; mA20 = a20; mExt = ext; mLow = low; mNc = nc; mBase = base; mLog2 = lg;
  endtask

  task automatic access(string tag, logic [31:0] a, logic mN, logic eN);
    @(negedge clk);
    addrValid = 1; addrIn = a; a20MaskN = mN; extCacheEnN = eN;
    expC.push_back(modelCache(a, mN, eN));
    expA.push_back(modelAddr(a, mN));
    expT.push_back(tag);
    @(negedge clk);
    addrValid = 0;
  endtask

  // monitor: one result per strobe, compared after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && addrValid) begin
        @(negedge clk);
        if (expC.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: unexpected result actual %h expected none", lookupAddr);
        end else begin
          lastC = expC.pop_front();
          lastA = expA.pop_front();
          begin
            string t = expT.pop_front();
            check({t, " cacheable"}, {31'd0, cacheable}, {31'd0, lastC});
            check({t, " lookup"}, lookupAddr, lastA);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cacheable", {31'd0, cacheable}, 32'd0);
    check("R1 reset lookup", lookupAddr, 32'd0);
    rstN = 1;
    // no configuration yet: caching off, optional pins ignored
    access("R1 unconfigured", 32'h0023_4560, 1'b0, 1'b1);
    loadCfg(1, 0, 0, 0, 0, 0, 0);
    access("R4 low 64KB of 2MB block", 32'h0020_1234, 1, 0);
    access("R4 low 64KB of block 0", 32'h0000_8000, 1, 0);
    access("R4 above 64KB cacheable", 32'h0021_0000, 1, 0);
    access("R6 ext ignored when off", 32'h0034_0000, 1, 1);
    access("R3 mask ignored when off", 32'h0013_0000, 0, 0);
    // R2 hold: outputs stay while inputs move without a strobe
    @(negedge clk);
    addrIn = 32'hFFFF_FFFF; a20MaskN = 0; extCacheEnN = 1;
    repeat (3) @(negedge clk);
    check("R2 hold cacheable", {31'd0, cacheable}, {31'd0, lastC});
    check("R2 hold lookup", lookupAddr, lastA);
    loadCfg(1, 0, 0, 1, 0, 0, 0);
    access("R5 lifted low region", 32'h0030_4000, 1, 0);
    loadCfg(1, 1, 1, 1, 0, 0, 0);
    access("R3 bit20 masked", 32'h0017_2340, 0, 0);
    access("R3 bit20 kept", 32'h0017_2340, 1, 0);
    access("R6 ext veto", 32'h0045_0000, 1, 1);
    access("R6 ext allows", 32'h0045_0000, 1, 0);
    loadCfg(1, 1, 0, 1, 1, 32'h0000_0000, 16);
    access("R7 window hit via mask", 32'h0010_1000, 0, 0);
    access("R7 outside window", 32'h0010_1000, 1, 0);
    loadCfg(1, 0, 0, 1, 1, 32'h00A0_0000, 20);
    access("R7 window hit", 32'h00AF_FF00, 1, 0);
    access("R7 window edge miss", 32'h00B0_0000, 1, 0);
    loadCfg(1, 0, 0, 1, 1, 32'h0, 32);
    access("R7 full-size window", 32'hCAFE_0000, 1, 0);
    loadCfg(0, 0, 0, 1, 0, 0, 0);
    access("R8 global off", 32'h0055_0000, 1, 0);
    // R9: load and access in the same edge: old (off) config judges it
    @(negedge clk);
    cfgLoad = 1; cfgCacheOn = 1; cfgLowMegOk = 1; cfgNcOn = 0;
    addrValid = 1; addrIn = 32'h0066_0000; a20MaskN = 1; extCacheEnN = 0;
    expC.push_back(modelCache(32'h0066_0000, 1, 0));
    expA.push_back(32'h0066_0000);
    expT.push_back("R9 same-edge uses old cfg");
    @(negedge clk);
    cfgLoad = 0; addrValid = 0;
    mOn = 1; mLow = 1; mNc = 0; mA20 = 0; mExt = 0;
    access("R9 new cfg next access", 32'h0066_0000, 1, 0);
    // reset mid-run clears configuration again
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    mOn = 0; mA20 = 0; mExt = 0; mLow = 0; mNc = 0;
    check("R1 reset again lookup", lookupAddr, 32'd0);
    access("R1 config cleared", 32'h0077_0000, 1, 0);
    repeat (3) @(negedge clk);
    check("R2 all results seen", expC.size(), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule